// File: doc/BRIEF.md
# Host-EC Indexed Mailbox Controller

This block is a bank of byte-wide mailbox registers shared by a host processor and an embedded controller (EC). The host reaches the bank only through a two-byte access port. A write to the pointer byte (port offset 0) selects a register, and each later access to the data byte (port offset 1) transfers that register's contents. The EC can read and write any register directly by its index. The EC can also use a second copy of the same two-byte port, and that copy shares the one pointer register with the host.

Thirty-two general bytes carry plain data in either direction. Four more registers carry signalling. The host writes a doorbell byte to raise an interrupt on the EC side. The EC writes a reply byte to raise an interrupt request toward the host. A source/enable pair drives an active-low SMI level. The same SMI level is also presented as an active-low request for the serial interrupt framer.

Top module: `hec_mailbox`

## Requirements
- R1: There are NUM_GEN+4 registers at indices 0..NUM_GEN+3 (36 by default). Indices 0..NUM_GEN-1 are general bytes. A byte that the host writes through the data port is read back by the EC directly, and a byte that the EC writes directly is read back by the host through the data port.
- R2: A write to port offset 0 loads the pointer, and a read of offset 0 returns the pointer. Accesses to offset 1 use the register the pointer selects. The pointer keeps its value across data accesses.
- R3: The EC copy of the port shares the pointer with the host. If both write the pointer in the same cycle, the host value is kept.
- R4: A pointer or direct index of NUM_GEN+4 or more reads as 0x00, and writes to it change no register.
- R5: If the host and the EC write the same register in the same cycle, the host byte is kept.
- R6: Index NUM_GEN (32) is the host-to-EC doorbell. A host data-port write to it sets ec_irq_o from the next cycle on. An EC read of index 32, direct or through its port, clears ec_irq_o, but a host write in the same cycle wins. An EC write to index 32 does not set ec_irq_o.
- R7: Index NUM_GEN+1 (33) is the EC-to-host reply. An EC write to it sets host_irq_o from the next cycle on. Only a host data-port read of index 33 clears host_irq_o.
- R8: Index NUM_GEN+2 (34) is the SMI source. An EC write ORs the written 1 bits into the source. A host write clears each source bit that is written as 1.
- R9: Index NUM_GEN+3 (35) is a read/write SMI enable byte. smi_n_o and smi_frame_n_o are both low exactly when (source AND enable) is non-zero, starting the cycle after the write that makes it so.
- R10: Reset makes every register, the pointer and both interrupt outputs zero, and it holds smi_n_o and smi_frame_n_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host port access strobe |
| host_we_i | input | 1 | Host port write (1) / read (0) |
| host_addr_i | input | 1 | Host port offset: 0 pointer, 1 data |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| ecp_req_i | input | 1 | EC port access strobe |
| ecp_we_i | input | 1 | EC port write / read |
| ecp_addr_i | input | 1 | EC port offset: 0 pointer, 1 data |
| ecp_wdata_i | input | 8 | EC port write byte |
| ecp_rdata_o | output | 8 | EC port read byte |
| ec_req_i | input | 1 | EC direct access strobe |
| ec_we_i | input | 1 | EC direct write / read |
| ec_addr_i | input | 8 | EC direct register index |
| ec_wdata_i | input | 8 | EC direct write byte |
| ec_rdata_o | output | 8 | EC direct read byte |
| ec_irq_o | output | 1 | Doorbell interrupt to EC |
| host_irq_o | output | 1 | Reply interrupt event toward host |
| smi_n_o | output | 1 | Active-low SMI level |
| smi_frame_n_o | output | 1 | Active-low SMI request for the serial IRQ framer |

## Verification
The bench builds the block with the default NUM_GEN of 32. This places the signalling registers at 32..35 and makes 36 the first out-of-range index. With these values the checks reach the last general byte (31) and the boundary between general and signalling storage. They also cover the first rejected index (36) and a far index (200), which shows that out-of-range accesses neither alias onto low registers nor change them. Because the parameter is at its default, the bench can also drive same-cycle collisions on real indices: host against EC on a data byte, host against EC on the pointer, and doorbell set against doorbell clear.

// File: rtl/hec_mailbox_pkg.sv
package hec_mailbox_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SIG_CNT = 4;

  // order of signalling registers after the general bytes
  typedef enum logic [1:0] {
    SIG_H2E = 2'd0,
    SIG_E2H = 2'd1,
    SIG_SRC = 2'd2,
    SIG_MSK = 2'd3
  } sig_e;

  typedef struct packed {
    logic              en;
    logic [BYTE_W-1:0] sel;
    logic [BYTE_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/hec_idx_port.sv
module hec_idx_port
  import hec_mailbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_set_i,
  input  logic [BYTE_W-1:0] host_val_i,
  input  logic              ec_set_i,
  input  logic [BYTE_W-1:0] ec_val_i,
  output logic [BYTE_W-1:0] idx_o
);
  logic [BYTE_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         idx_q <= '0;
    else if (host_set_i) idx_q <= host_val_i;
    else if (ec_set_i)   idx_q <= ec_val_i;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/hec_gen_bank.sv
module hec_gen_bank
  import hec_mailbox_pkg::*;
#(
  parameter int unsigned NUM_GEN = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  wr_req_t                        host_wr_i,
  input  wr_req_t                        ec_wr_i,
  output logic [NUM_GEN-1:0][BYTE_W-1:0] mem_o
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_byte
    logic              host_hit, ec_hit;
    logic [BYTE_W-1:0] byte_q;

    assign host_hit = host_wr_i.en && (host_wr_i.sel == BYTE_W'(g));
    assign ec_hit   = ec_wr_i.en   && (ec_wr_i.sel   == BYTE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       byte_q <= '0;
      else if (host_hit) byte_q <= host_wr_i.data;
      else if (ec_hit)   byte_q <= ec_wr_i.data;
    end

    assign mem_o[g] = byte_q;
  end
endmodule

// File: rtl/hec_sig_regs.sv
module hec_sig_regs
  import hec_mailbox_pkg::*;
#(
  parameter int unsigned BASE = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  wr_req_t                        host_wr_i,
  input  wr_req_t                        ec_wr_i,
  input  logic                           host_rd_e2h_i,
  input  logic                           ec_rd_h2e_i,
  output logic [SIG_CNT-1:0][BYTE_W-1:0] regs_o,
  output logic                           ec_irq_o,
  output logic                           host_irq_o,
  output logic                           smi_n_o
);
  logic [SIG_CNT-1:0] host_hit, ec_hit;
  logic [BYTE_W-1:0]  h2e_q, e2h_q, src_q, msk_q;
  logic               ec_irq_q, host_irq_q;

  for (genvar s = 0; s < SIG_CNT; s++) begin : g_dec
    assign host_hit[s] = host_wr_i.en && (host_wr_i.sel == BYTE_W'(BASE + s));
    assign ec_hit[s]   = ec_wr_i.en   && (ec_wr_i.sel   == BYTE_W'(BASE + s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h2e_q <= '0;
      e2h_q <= '0;
      src_q <= '0;
      msk_q <= '0;
    end else begin
      if (host_hit[SIG_H2E])    h2e_q <= host_wr_i.data;
      else if (ec_hit[SIG_H2E]) h2e_q <= ec_wr_i.data;
      if (host_hit[SIG_E2H])    e2h_q <= host_wr_i.data;
      else if (ec_hit[SIG_E2H]) e2h_q <= ec_wr_i.data;
      // host clears by writing ones, EC posts by writing ones
      if (host_hit[SIG_SRC])    src_q <= src_q & ~host_wr_i.data;
      else if (ec_hit[SIG_SRC]) src_q <= src_q | ec_wr_i.data;
      if (host_hit[SIG_MSK])    msk_q <= host_wr_i.data;
      else if (ec_hit[SIG_MSK]) msk_q <= ec_wr_i.data;
    end
  end

  // set has priority over clear on both interrupt flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ec_irq_q   <= 1'b0;
      host_irq_q <= 1'b0;
    end else begin
      if (host_hit[SIG_H2E])  ec_irq_q <= 1'b1;
      else if (ec_rd_h2e_i)   ec_irq_q <= 1'b0;
      if (ec_hit[SIG_E2H] && !host_hit[SIG_E2H]) host_irq_q <= 1'b1;
      else if (host_rd_e2h_i)                    host_irq_q <= 1'b0;
    end
  end

  assign regs_o[SIG_H2E] = h2e_q;
  assign regs_o[SIG_E2H] = e2h_q;
  assign regs_o[SIG_SRC] = src_q;
  assign regs_o[SIG_MSK] = msk_q;
  assign ec_irq_o        = ec_irq_q;
  assign host_irq_o      = host_irq_q;
  assign smi_n_o         = ~|(src_q & msk_q);
endmodule

// File: rtl/hec_mailbox.sv
module hec_mailbox
  import hec_mailbox_pkg::*;
#(
  parameter int unsigned NUM_GEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_addr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              ecp_req_i,
  input  logic              ecp_we_i,
  input  logic              ecp_addr_i,
  input  logic [BYTE_W-1:0] ecp_wdata_i,
  output logic [BYTE_W-1:0] ecp_rdata_o,
  input  logic              ec_req_i,
  input  logic              ec_we_i,
  input  logic [BYTE_W-1:0] ec_addr_i,
  input  logic [BYTE_W-1:0] ec_wdata_i,
  output logic [BYTE_W-1:0] ec_rdata_o,
  output logic              ec_irq_o,
  output logic              host_irq_o,
  output logic              smi_n_o,
  output logic              smi_frame_n_o
);
  localparam int unsigned     NUM_REGS = NUM_GEN + SIG_CNT;
  localparam int unsigned     GEN_AW   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
  localparam logic [BYTE_W-1:0] GEN_LIM = BYTE_W'(NUM_GEN);
  localparam logic [BYTE_W-1:0] REG_LIM = BYTE_W'(NUM_REGS);
  localparam logic [BYTE_W-1:0] H2E_IDX = BYTE_W'(NUM_GEN + SIG_H2E);
  localparam logic [BYTE_W-1:0] E2H_IDX = BYTE_W'(NUM_GEN + SIG_E2H);

  logic [BYTE_W-1:0]               idx_q;
  logic [NUM_GEN-1:0][BYTE_W-1:0]  mem;
  logic [SIG_CNT-1:0][BYTE_W-1:0]  sig;
  logic host_idx_wr, host_dat_wr, host_dat_rd;
  logic ecp_idx_wr, ecp_dat_wr, ecp_dat_rd;
  logic ec_dir_wr, ec_dir_rd;
  logic idx_ok, ec_addr_ok, smi_n;
  logic host_rd_e2h, ec_rd_h2e;
  wr_req_t host_wr, ec_wr;

  function automatic logic [BYTE_W-1:0] rd_mux(input logic [BYTE_W-1:0] sel);
    logic [BYTE_W-1:0] off;
    off = sel - GEN_LIM;
    if (sel < GEN_LIM)      rd_mux = mem[sel[GEN_AW-1:0]];
    else if (sel < REG_LIM) rd_mux = sig[off[1:0]];
    else                    rd_mux = '0;
  endfunction

  assign host_idx_wr = host_req_i &  host_we_i & ~host_addr_i;
  assign host_dat_wr = host_req_i &  host_we_i &  host_addr_i;
  assign host_dat_rd = host_req_i & ~host_we_i &  host_addr_i;
  assign ecp_idx_wr  = ecp_req_i  &  ecp_we_i  & ~ecp_addr_i;
  assign ecp_dat_wr  = ecp_req_i  &  ecp_we_i  &  ecp_addr_i;
  assign ecp_dat_rd  = ecp_req_i  & ~ecp_we_i  &  ecp_addr_i;
  assign ec_dir_wr   = ec_req_i   &  ec_we_i;
  assign ec_dir_rd   = ec_req_i   & ~ec_we_i;

  assign idx_ok     = idx_q < REG_LIM;
  assign ec_addr_ok = ec_addr_i < REG_LIM;

  hec_idx_port u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_set_i (host_idx_wr),
    .host_val_i (host_wdata_i),
    .ec_set_i   (ecp_idx_wr),
    .ec_val_i   (ecp_wdata_i),
    .idx_o      (idx_q)
  );

  always_comb begin
    host_wr.en   = host_dat_wr & idx_ok;
    host_wr.sel  = idx_q;
    host_wr.data = host_wdata_i;
    // EC direct path outranks the EC copy of the port
    if (ec_dir_wr && ec_addr_ok) begin
      ec_wr.en   = 1'b1;
      ec_wr.sel  = ec_addr_i;
      ec_wr.data = ec_wdata_i;
    end else begin
      ec_wr.en   = ecp_dat_wr & idx_ok;
      ec_wr.sel  = idx_q;
      ec_wr.data = ecp_wdata_i;
    end
  end

  assign host_rd_e2h = host_dat_rd && (idx_q == E2H_IDX);
  assign ec_rd_h2e   = (ec_dir_rd && (ec_addr_i == H2E_IDX)) ||
                       (ecp_dat_rd && (idx_q == H2E_IDX));

  hec_gen_bank #(.NUM_GEN(NUM_GEN)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .host_wr_i (host_wr),
    .ec_wr_i   (ec_wr),
    .mem_o     (mem)
  );

  hec_sig_regs #(.BASE(NUM_GEN)) u_sig (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_wr_i     (host_wr),
    .ec_wr_i       (ec_wr),
    .host_rd_e2h_i (host_rd_e2h),
    .ec_rd_h2e_i   (ec_rd_h2e),
    .regs_o        (sig),
    .ec_irq_o      (ec_irq_o),
    .host_irq_o    (host_irq_o),
    .smi_n_o       (smi_n)
  );

  assign host_rdata_o  = host_addr_i ? rd_mux(idx_q) : idx_q;
  assign ecp_rdata_o   = ecp_addr_i  ? rd_mux(idx_q) : idx_q;
  assign ec_rdata_o    = rd_mux(ec_addr_i);
  assign smi_n_o       = smi_n;
  assign smi_frame_n_o = smi_n;
endmodule

// File: rtl/hec_mailbox_chk.sv
module hec_mailbox_chk #(
  parameter int unsigned NUM_GEN = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_req_i,
  input logic       host_we_i,
  input logic       host_addr_i,
  input logic [7:0] host_wdata_i,
  input logic [7:0] host_rdata_o,
  input logic       ecp_req_i,
  input logic       ecp_we_i,
  input logic       ecp_addr_i,
  input logic       ec_req_i,
  input logic       ec_we_i,
  input logic [7:0] ec_addr_i,
  input logic [7:0] idx_q,
  input logic       ec_irq_o,
  input logic       host_irq_o
);
  localparam logic [7:0] H2E = 8'(NUM_GEN);
  localparam logic [7:0] E2H = 8'(NUM_GEN + 1);
  localparam logic [7:0] LIM = 8'(NUM_GEN + 4);

  logic h_idx_wr, h_dat_wr, h_dat_rd, ec_h2e_rd, ec_e2h_wr;
  assign h_idx_wr  = host_req_i & host_we_i & ~host_addr_i;
  assign h_dat_wr  = host_req_i & host_we_i & host_addr_i;
  assign h_dat_rd  = host_req_i & ~host_we_i & host_addr_i;
  assign ec_h2e_rd = (ec_req_i & ~ec_we_i & (ec_addr_i == H2E)) |
                     (ecp_req_i & ~ecp_we_i & ecp_addr_i & (idx_q == H2E));
  assign ec_e2h_wr = (ec_req_i & ec_we_i & (ec_addr_i == E2H)) |
                     (ecp_req_i & ecp_we_i & ecp_addr_i & (idx_q == E2H));

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_idx_wr |=> idx_q == $past(host_wdata_i)); // R2
  AST_OOR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_dat_rd && idx_q >= LIM) |-> host_rdata_o == 8'h00); // R4
  AST_EIRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_dat_wr && idx_q == H2E) |=> ec_irq_o); // R6
  AST_EIRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ec_irq_o && !ec_h2e_rd) |=> ec_irq_o); // R6
  AST_HIRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ec_req_i && ec_we_i && ec_addr_i == E2H && !(h_dat_wr && idx_q == E2H)) |=> host_irq_o); // R7
  AST_HIRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_dat_rd && idx_q == E2H && !ec_e2h_wr) |=> !host_irq_o); // R7
endmodule

bind hec_mailbox hec_mailbox_chk #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_req_i   (host_req_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .ecp_req_i    (ecp_req_i),
  .ecp_we_i     (ecp_we_i),
  .ecp_addr_i   (ecp_addr_i),
  .ec_req_i     (ec_req_i),
  .ec_we_i      (ec_we_i),
  .ec_addr_i    (ec_addr_i),
  .idx_q        (idx_q),
  .ec_irq_o     (ec_irq_o),
  .host_irq_o   (host_irq_o)
);

// File: tb/sim_hec_mailbox.sv
module sim_hec_mailbox;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req, host_we, host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       ecp_req, ecp_we, ecp_addr;
  logic [7:0] ecp_wdata, ecp_rdata;
  logic       ec_req, ec_we;
  logic [7:0] ec_addr, ec_wdata, ec_rdata;
  logic       ec_irq, host_irq, smi_n, smi_frame_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk; // 50 MHz

  hec_mailbox u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .ecp_req_i(ecp_req), .ecp_we_i(ecp_we), .ecp_addr_i(ecp_addr),
    .ecp_wdata_i(ecp_wdata), .ecp_rdata_o(ecp_rdata),
    .ec_req_i(ec_req), .ec_we_i(ec_we), .ec_addr_i(ec_addr),
    .ec_wdata_i(ec_wdata), .ec_rdata_o(ec_rdata),
    .ec_irq_o(ec_irq), .host_irq_o(host_irq),
    .smi_n_o(smi_n), .smi_frame_n_o(smi_frame_n)
  );

  localparam logic [3:0] OP_HIDX = 4'd0, OP_HWR = 4'd1, OP_HRD = 4'd2,
                         OP_EWR  = 4'd3, OP_ERD = 4'd4, OP_PIDX = 4'd5,
                         OP_PWR  = 4'd6, OP_PRD = 4'd7, OP_HIRD = 4'd8;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    '{OP_HIDX, 8'h00, 8'h05, 8'h00, 4'd0},
    '{OP_HWR,  8'h00, 8'hA5, 8'h00, 4'd0},
    '{OP_ERD,  8'h05, 8'h00, 8'hA5, 4'd1},  // R1 host->EC
    '{OP_EWR,  8'h1F, 8'h3C, 8'h00, 4'd0},
    '{OP_HIDX, 8'h00, 8'h1F, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h3C, 4'd1},  // R1 EC->host, last general byte
    '{OP_HIRD, 8'h00, 8'h00, 8'h1F, 4'd2},  // R2 pointer readback
    '{OP_HWR,  8'h00, 8'h77, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h77, 4'd2},  // R2 pointer persists
    '{OP_PIDX, 8'h00, 8'h07, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h00, 4'd3},  // R3 shared pointer
    '{OP_PWR,  8'h00, 8'h99, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h99, 4'd3},
    '{OP_PRD,  8'h00, 8'h00, 8'h99, 4'd3},
    '{OP_HIDX, 8'h00, 8'h24, 8'h00, 4'd0},
    '{OP_HWR,  8'h00, 8'hFF, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h00, 4'd4},  // R4 index 36
    '{OP_EWR,  8'h24, 8'h11, 8'h00, 4'd0},
    '{OP_ERD,  8'h24, 8'h00, 8'h00, 4'd4},
    '{OP_HIDX, 8'h00, 8'hC8, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h00, 4'd4},  // R4 index 200
    '{OP_ERD,  8'h00, 8'h00, 8'h00, 4'd4},  // R4 no alias onto 0
    '{OP_EWR,  8'h23, 8'h0F, 8'h00, 4'd0},
    '{OP_HIDX, 8'h00, 8'h23, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h0F, 4'd9},  // R9 enable readback
    '{OP_EWR,  8'h22, 8'h30, 8'h00, 4'd0},
    '{OP_EWR,  8'h22, 8'h03, 8'h00, 4'd0},
    '{OP_ERD,  8'h22, 8'h00, 8'h33, 4'd8},  // R8 EC ORs in
    '{OP_HIDX, 8'h00, 8'h22, 8'h00, 4'd0},
    '{OP_HWR,  8'h00, 8'h01, 8'h00, 4'd0},
    '{OP_HRD,  8'h00, 8'h00, 8'h32, 4'd8}   // R8 host clears ones
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clr();
    host_req = 0; host_we = 0; host_addr = 0; host_wdata = '0;
    ecp_req = 0; ecp_we = 0; ecp_addr = 0; ecp_wdata = '0;
    ec_req = 0; ec_we = 0; ec_addr = '0; ec_wdata = '0;
  endtask

  task automatic idle();
    @(negedge clk); clr(); #5;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] d, output logic [7:0] r);
    @(negedge clk); clr();
    case (op)
      OP_HIDX: begin host_req = 1; host_we = 1; host_addr = 0; host_wdata = d; end
      OP_HWR:  begin host_req = 1; host_we = 1; host_addr = 1; host_wdata = d; end
      OP_HRD:  begin host_req = 1; host_addr = 1; end
      OP_HIRD: begin host_req = 1; host_addr = 0; end
      OP_EWR:  begin ec_req = 1; ec_we = 1; ec_addr = a; ec_wdata = d; end
      OP_ERD:  begin ec_req = 1; ec_addr = a; end
      OP_PIDX: begin ecp_req = 1; ecp_we = 1; ecp_addr = 0; ecp_wdata = d; end
      OP_PWR:  begin ecp_req = 1; ecp_we = 1; ecp_addr = 1; ecp_wdata = d; end
      OP_PRD:  begin ecp_req = 1; ecp_addr = 1; end
      default: ;
    endcase
    #5;
    r = (op == OP_ERD) ? ec_rdata : (op == OP_PRD) ? ecp_rdata : host_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    #5;
    chk("R10 ec_irq", {7'd0, ec_irq}, 8'h00);
    chk("R10 host_irq", {7'd0, host_irq}, 8'h00);
    chk("R10 smi", {6'd0, smi_n, smi_frame_n}, 8'h03);
    do_op(OP_HIRD, 0, 0, r); chk("R10 pointer", r, 8'h00);
    do_op(OP_ERD, 8'h05, 0, r); chk("R10 byte", r, 8'h00);

    for (int i = 0; i < NV; i++) begin
      do_op(VT[i].op, VT[i].a, VT[i].d, r);
      if (VT[i].r != 0) chk($sformatf("R%0d vec%0d", VT[i].r, i), r, VT[i].e);
    end

    // R9 SMI level: src 0x32, enable 0x0F
    idle();
    chk("R9 smi low", {6'd0, smi_n, smi_frame_n}, 8'h00);
    do_op(OP_HWR, 0, 8'h02, r); idle(); // pointer still 34
    chk("R9 smi high after clear", {6'd0, smi_n, smi_frame_n}, 8'h03);
    do_op(OP_EWR, 8'h23, 8'hF0, r); idle();
    chk("R9 smi low new enable", {6'd0, smi_n, smi_frame_n}, 8'h00);
    do_op(OP_EWR, 8'h23, 8'h00, r); idle();
    chk("R9 smi high no enable", {6'd0, smi_n, smi_frame_n}, 8'h03);

    // R6 doorbell
    do_op(OP_HIDX, 0, 8'h20, r);
    do_op(OP_HWR, 0, 8'h44, r); idle();
    chk("R6 irq set", {7'd0, ec_irq}, 8'h01);
    do_op(OP_ERD, 8'h20, 0, r); chk("R6 data", r, 8'h44);
    idle(); chk("R6 irq clear", {7'd0, ec_irq}, 8'h00);
    do_op(OP_HWR, 0, 8'h55, r);
    @(negedge clk); clr();
    host_req = 1; host_we = 1; host_addr = 1; host_wdata = 8'h66;
    ec_req = 1; ec_addr = 8'h20;
    idle(); chk("R6 set wins", {7'd0, ec_irq}, 8'h01);
    do_op(OP_PRD, 0, 0, r); chk("R6 port data", r, 8'h66);
    idle(); chk("R6 port clear", {7'd0, ec_irq}, 8'h00);
    do_op(OP_EWR, 8'h20, 8'h77, r); idle();
    chk("R6 EC write no irq", {7'd0, ec_irq}, 8'h00);

    // R7 reply
    do_op(OP_EWR, 8'h21, 8'h5A, r); idle();
    chk("R7 irq set", {7'd0, host_irq}, 8'h01);
    do_op(OP_HIDX, 0, 8'h00, r);
    do_op(OP_HRD, 0, 0, r); idle();
    chk("R7 other read keeps", {7'd0, host_irq}, 8'h01);
    do_op(OP_HIDX, 0, 8'h21, r);
    do_op(OP_HRD, 0, 0, r); chk("R7 data", r, 8'h5A);
    idle(); chk("R7 irq clear", {7'd0, host_irq}, 8'h00);

    // R5 collision
    do_op(OP_HIDX, 0, 8'h0A, r);
    @(negedge clk); clr();
    host_req = 1; host_we = 1; host_addr = 1; host_wdata = 8'h11;
    ec_req = 1; ec_we = 1; ec_addr = 8'h0A; ec_wdata = 8'h22;
    do_op(OP_HRD, 0, 0, r); chk("R5 host wins", r, 8'h11);

    // R3 pointer collision
    @(negedge clk); clr();
    host_req = 1; host_we = 1; host_addr = 0; host_wdata = 8'h03;
    ecp_req = 1; ecp_we = 1; ecp_addr = 0; ecp_wdata = 8'h04;
    do_op(OP_HIRD, 0, 0, r); chk("R3 host pointer wins", r, 8'h03);

    // R10 mid-run reset
    do_op(OP_EWR, 8'h21, 8'h01, r); idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #5;
    chk("R10 host_irq after reset", {7'd0, host_irq}, 8'h00);
    do_op(OP_ERD, 8'h0A, 0, r); chk("R10 byte after reset", r, 8'h00);
    do_op(OP_ERD, 8'h22, 0, r); chk("R10 source after reset", r, 8'h00);
    do_op(OP_HIRD, 0, 0, r); chk("R10 pointer after reset", r, 8'h00);

    done = 1;
    finish_run();
  end
endmodule